// File: doc/BRIEF.md
# Four-Lane Output Formatter

This block shapes four 12-bit result lanes for a receiver front end. It accepts one beat carrying two candidate source groups. The first group is the four mixer results: even I, even Q, odd I and odd Q. The second group is the four symbol-path samples: symbol I, symbol Q, cosine and sine. Each output lane picks one group on its own. The pairing between source slots and lanes is fixed.

Each lane can also round its value to 10 or 8 significant bits, or pass it at the full 12 bits. It then clears bits through its own 12-bit mask word. A disabled lane drives zero. The configuration is captured with the data when a beat is accepted, and the formatted lanes appear one cycle later from a register.

Data moves under a valid/ready handshake. The block accepts a beat when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new beat is taken.

Top module: `ofmt_top`

## Requirements
- R1: After reset, `out_valid` is 0, `y_data` is all zeros and `in_ready` is 1.
- R2: With lane select bit 0, lanes 0..3 carry the mixer words from `mix_data` slots 0..3 (even I, even Q, odd I, odd Q). Lane n occupies bits [12n+11:12n] on every bus.
- R3: With lane select bit 1, lanes 0..3 carry the `snap_data` slots 0..3 (symbol I, symbol Q, cosine, sine). Each lane follows its own bit of `src_sel`, so select patterns can be mixed across lanes.
- R4: Precision code 0 (full) and code 3 (treated as full) pass the selected word unchanged. Lane n uses `prec_sel[2n+1:2n]`.
- R5: Precision code 1 keeps 10 bits. The block adds 2 to the two's-complement word, clears bits [1:0], and saturates a positive overflow to 0x7FC.
- R6: Precision code 2 keeps 8 bits. The block adds 8, clears bits [3:0], and saturates a positive overflow to 0x7F0. Negative inputs round toward the next multiple of 16 and never saturate.
- R7: The rounded word is bitwise ANDed with the lane's mask word, so an output bit is 1 only where its mask bit is 1.
- R8: A lane whose `port_en` bit is 0 outputs 0, whatever its source, precision and mask.
- R9: An accepted beat appears on `y_data` with `out_valid` high at the next rising edge. With no beat accepted and `out_ready` high, `out_valid` falls at the next edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `y_data` stays stable.
- R11: Configuration is sampled with the beat at acceptance. A configuration change during a stall does not alter the held output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| mix_data | input | 48 | Mixer words, four 12-bit slots |
| snap_data | input | 48 | Symbol/oscillator words, four 12-bit slots |
| src_sel | input | 4 | Per-lane source select (0 mixer, 1 symbol path) |
| prec_sel | input | 8 | Per-lane 2-bit precision code |
| mask_word | input | 48 | Per-lane 12-bit AND mask |
| port_en | input | 4 | Per-lane enable |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| y_data | output | 48 | Four formatted 12-bit lanes |

## Verification
The bench drives the largest positive words into both reduced precisions. A rounder without saturation would wrap these to large negative values rather than 0x7FC or 0x7F0. Small and negative words near the rounding threshold expose an off-by-one half-LSB or a missing clear of the low bits. Mixed select patterns and one-hot enables catch a swapped slot or a lane that follows another lane's control. A stall with the configuration changed underneath it shows whether the held beat is recomputed from live inputs instead of being frozen, and whether a beat is dropped or duplicated on release.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;
  typedef enum logic [1:0] {
    PREC_FULL = 2'd0,
    PREC_MID  = 2'd1,
    PREC_LOW  = 2'd2,
    PREC_RSVD = 2'd3
  } prec_t;
endpackage

// File: rtl/ofmt_src_sel.sv
module ofmt_src_sel #(
  parameter int unsigned DW = 12
) (
  input  logic          sel,
  input  logic [DW-1:0] mix_word,
  input  logic [DW-1:0] snap_word,
  output logic [DW-1:0] word_out
);
  always_comb begin
    if (sel) word_out = snap_word;
    else     word_out = mix_word;
  end
endmodule

// File: rtl/ofmt_round_stage.sv
module ofmt_round_stage #(
  parameter int unsigned DW   = 12,
  parameter int unsigned DROP = 2
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam logic [DW-1:0] ONE    = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] HALF   = ONE << (DROP - 1);
  localparam logic [DW-1:0] KEEP   = {DW{1'b1}} << DROP;
  localparam logic [DW-1:0] POSMAX = {1'b0, {(DW-1){1'b1}}} & KEEP;

  logic [DW-1:0] sum;
  logic          ovf;

  always_comb begin
    sum  = din + HALF;
    // only a non-negative word can cross the top of the range
    ovf  = !din[DW-1] && sum[DW-1];
    dout = ovf ? POSMAX : (sum & KEEP);
  end
endmodule

// File: rtl/ofmt_rounder.sv
module ofmt_rounder
  import ofmt_pkg::*;
#(
  parameter int unsigned DW       = 12,
  parameter int unsigned DROP_MID = 2,
  parameter int unsigned DROP_LOW = 4
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    prec,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mid_w;
  logic [DW-1:0] low_w;

  ofmt_round_stage #(.DW(DW), .DROP(DROP_MID)) mid_i (.din(din), .dout(mid_w));
  ofmt_round_stage #(.DW(DW), .DROP(DROP_LOW)) low_i (.din(din), .dout(low_w));

  always_comb begin
    case (prec)
      PREC_MID: dout = mid_w;
      PREC_LOW: dout = low_w;
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/ofmt_gate.sv
module ofmt_gate #(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] mask,
  input  logic          en,
  output logic [DW-1:0] dout
);
  always_comb begin
    if (en) dout = din & mask;
    else    dout = '0;
  end
endmodule

// File: rtl/ofmt_top.sv
module ofmt_top #(
  parameter int unsigned NPORTS   = 4,
  parameter int unsigned DW       = 12,
  parameter int unsigned DROP_MID = 2,
  parameter int unsigned DROP_LOW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NPORTS*DW-1:0] mix_data,
  input  logic [NPORTS*DW-1:0] snap_data,
  input  logic [NPORTS-1:0]    src_sel,
  input  logic [2*NPORTS-1:0]  prec_sel,
  input  logic [NPORTS*DW-1:0] mask_word,
  input  logic [NPORTS-1:0]    port_en,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NPORTS*DW-1:0] y_data
);
  localparam int unsigned BUSW = NPORTS * DW;

  logic [BUSW-1:0] fmt_bus;
  logic [BUSW-1:0] y_q;
  logic            vld_q;
  logic            accept;

  always_comb begin
    in_ready = !vld_q || out_ready;
    accept   = in_valid && in_ready;
  end

  for (genvar g = 0; g < NPORTS; g++) begin : g_lane
    logic [DW-1:0] src_w;
    logic [DW-1:0] rnd_w;
    logic [DW-1:0] out_w;

    ofmt_src_sel #(.DW(DW)) sel_i (
      .sel      (src_sel[g]),
      .mix_word (mix_data[g*DW +: DW]),
      .snap_word(snap_data[g*DW +: DW]),
      .word_out (src_w)
    );

    ofmt_rounder #(.DW(DW), .DROP_MID(DROP_MID), .DROP_LOW(DROP_LOW)) rnd_i (
      .din (src_w),
      .prec(prec_sel[2*g +: 2]),
      .dout(rnd_w)
    );

    ofmt_gate #(.DW(DW)) gate_i (
      .din (rnd_w),
      .mask(mask_word[g*DW +: DW]),
      .en  (port_en[g]),
      .dout(out_w)
    );

    assign fmt_bus[g*DW +: DW] = out_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (accept) begin
        y_q   <= fmt_bus;
        vld_q <= 1'b1;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign y_data    = y_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/ofmt_checker.sv
module ofmt_checker #(
  parameter int unsigned NPORTS   = 4,
  parameter int unsigned DW       = 12,
  parameter int unsigned DROP_MID = 2,
  parameter int unsigned DROP_LOW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [NPORTS*DW-1:0] mask_word,
  input logic [2*NPORTS-1:0]  prec_sel,
  input logic [NPORTS-1:0]    port_en,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NPORTS*DW-1:0] y_data
);
  localparam logic [DW-1:0] MID_LOW_BITS = ~({DW{1'b1}} << DROP_MID);
  localparam logic [DW-1:0] LOW_LOW_BITS = ~({DW{1'b1}} << DROP_LOW);

  logic acc;
  assign acc = in_valid && in_ready;

  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_drain_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && out_ready) |=> !out_valid);

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(y_data)));

  assert_mask_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((y_data & ~$past(mask_word)) == '0));

  for (genvar g = 0; g < NPORTS; g++) begin : g_chk
    assert_lane_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !port_en[g]) |=> (y_data[g*DW +: DW] == '0));

    assert_mid_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && prec_sel[2*g +: 2] == 2'd1) |=> ((y_data[g*DW +: DW] & MID_LOW_BITS) == '0));

    assert_low_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && prec_sel[2*g +: 2] == 2'd2) |=> ((y_data[g*DW +: DW] & LOW_LOW_BITS) == '0));
  end
endmodule

bind ofmt_top ofmt_checker #(
  .NPORTS(NPORTS), .DW(DW), .DROP_MID(DROP_MID), .DROP_LOW(DROP_LOW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .mask_word(mask_word),
  .prec_sel (prec_sel),
  .port_en  (port_en),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .y_data   (y_data)
);

// File: tb/ofmt_top_tb_top.sv
`timescale 1ns/1ps
module ofmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] mix_data = '0;
  logic [47:0] snap_data = '0;
  logic [3:0]  src_sel = '0;
  logic [7:0]  prec_sel = '0;
  logic [47:0] mask_word = '1;
  logic [3:0]  port_en = '1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [47:0] y_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ofmt_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mix_data(mix_data), .snap_data(snap_data), .src_sel(src_sel),
    .prec_sel(prec_sel), .mask_word(mask_word), .port_en(port_en),
    .out_valid(out_valid), .out_ready(out_ready), .y_data(y_data)
  );

  function automatic logic [11:0] m_drop(input logic [11:0] x, input int d);
    logic [11:0] s;
    logic [11:0] keep;
    keep = 12'hFFF << d;
    s = x + (12'd1 << (d - 1));
    if (!x[11] && s[11]) return 12'h7FF & keep;
    return s & keep;
  endfunction

  function automatic logic [47:0] model(input logic [47:0] mx, input logic [47:0] sn,
      input logic [3:0] sel, input logic [7:0] pr, input logic [47:0] mk, input logic [3:0] en);
    logic [47:0] r;
    r = '0;
    for (int p = 0; p < 4; p++) begin
      logic [11:0] w;
      w = sel[p] ? sn[p*12 +: 12] : mx[p*12 +: 12];
      if (pr[2*p +: 2] == 2'd1) w = m_drop(w, 2);
      else if (pr[2*p +: 2] == 2'd2) w = m_drop(w, 4);
      w = w & mk[p*12 +: 12];
      if (!en[p]) w = '0;
      r[p*12 +: 12] = w;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [47:0] mx, input logic [47:0] sn, input logic [3:0] sel,
      input logic [7:0] pr, input logic [47:0] mk, input logic [3:0] en, input string req);
    logic [47:0] exp;
    exp = model(mx, sn, sel, pr, mk, en);
    @(negedge clk);
    mix_data = mx; snap_data = sn; src_sel = sel; prec_sel = pr;
    mask_word = mk; port_en = en; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, " valid"}, {47'd0, out_valid}, 48'd1);
    check(y_data === exp, req, y_data, exp);
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R1 valid", {47'd0, out_valid}, 48'd0);
    check(y_data === 48'd0, "R1 data", y_data, 48'd0);
    check(in_ready === 1'b1, "R1 ready", {47'd0, in_ready}, 48'd1);
  endtask

  task automatic t_mixer_map();
    beat(48'h444_333_222_111, 48'hDDD_CCC_BBB_AAA, 4'b0000, 8'h00, '1, 4'hF, "R2 mixer map");
    beat(48'h800_7FF_001_FFF, 48'h0, 4'b0000, 8'h00, '1, 4'hF, "R2 mixer extremes");
  endtask

  task automatic t_snap_map();
    beat(48'h444_333_222_111, 48'hDDD_CCC_BBB_AAA, 4'b1111, 8'h00, '1, 4'hF, "R3 snap map");
    beat(48'h444_333_222_111, 48'hDDD_CCC_BBB_AAA, 4'b0101, 8'h00, '1, 4'hF, "R3 mixed sel");
    beat(48'h444_333_222_111, 48'hDDD_CCC_BBB_AAA, 4'b1010, 8'h00, '1, 4'hF, "R3 mixed sel b");
  endtask

  task automatic t_full_prec();
    beat(48'h7FF_ABC_803_FFF, 48'h0, 4'b0000, 8'b11_00_11_00, '1, 4'hF, "R4 full/reserved");
  endtask

  task automatic t_round_mid();
    // 7FF sat->7FC, 001->000, 002->004, FFE->000
    beat(48'hFFE_002_001_7FF, 48'h0, 4'b0000, 8'h55, '1, 4'hF, "R5 mid round");
    check(y_data === 48'h000_004_000_7FC, "R5 literal", y_data, 48'h000_004_000_7FC);
  endtask

  task automatic t_round_low();
    // 7F8 sat->7F0, 800->800, 008->010, FF7->FF0
    beat(48'hFF7_008_800_7F8, 48'h0, 4'b0000, 8'hAA, '1, 4'hF, "R6 low round");
    check(y_data === 48'hFF0_010_800_7F0, "R6 literal", y_data, 48'hFF0_010_800_7F0);
  endtask

  task automatic t_mask();
    beat(48'hFFF_7FF_5A5_ABC, 48'h0, 4'b0000, 8'b00_10_01_00, 48'h0F0_FFF_00F_F0F, 4'hF, "R7 mask");
  endtask

  task automatic t_disable();
    for (int k = 0; k < 4; k++)
      beat(48'hFFF_FFF_FFF_FFF, 48'h7FF_7FF_7FF_7FF, 4'b0110, 8'h00, '1, 4'(1 << k), "R8 one lane on");
    beat(48'hFFF_FFF_FFF_FFF, 48'h0, 4'b0000, 8'h00, '1, 4'h0, "R8 all off");
  endtask

  task automatic t_latency();
    @(negedge clk);
    check(out_valid === 1'b0, "R9 idle drain", {47'd0, out_valid}, 48'd0);
  endtask

  task automatic t_stall();
    logic [47:0] a_exp;
    logic [47:0] b_exp;
    a_exp = model(48'h123_456_789_ABC, 48'h0, 4'h0, 8'h00, '1, 4'hF);
    b_exp = model(48'h123_456_789_ABC, 48'h0, 4'h0, 8'hAA, 48'hF0F_F0F_F0F_F0F, 4'b1011);
    @(negedge clk);
    mix_data = 48'h123_456_789_ABC; src_sel = '0; prec_sel = 8'h00;
    mask_word = '1; port_en = 4'hF; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    prec_sel = 8'hAA; mask_word = 48'hF0F_F0F_F0F_F0F; port_en = 4'b1011;
    for (int c = 0; c < 3; c++) begin
      check(in_ready === 1'b0, "R10 ready low", {47'd0, in_ready}, 48'd0);
      check(y_data === a_exp && out_valid === 1'b1, "R11 held beat", y_data, a_exp);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(y_data === b_exp && out_valid === 1'b1, "R10 release next", y_data, b_exp);
    @(negedge clk);
    check(out_valid === 1'b0, "R9 drained", {47'd0, out_valid}, 48'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mixer_map();
    t_snap_map();
    t_full_prec();
    t_round_mid();
    t_round_low();
    t_mask();
    t_disable();
    t_latency();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule